// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block is a clocked front end for an external asynchronous static RAM that holds 256K words of 32 bits. A user-side client issues one request at a time over a valid/ready handshake: a word address, a write flag, write data and a four-bit byte mask. The controller turns each request into a correctly timed memory cycle. Reads return their data with a one-cycle valid pulse.

The memory has one active-low enable per byte lane. Any mix of bytes can therefore be read or written, and lanes left out of the mask are never selected. All memory-side outputs come straight from registers. The wait counts are derived from the clock period and from the part's access, pulse and float times, each rounded up to whole cycles with a floor of one. The data bus is split into a drive-enable, an output bus and an input bus. After every read, a turnaround gap keeps the output enable and the bus driver from overlapping.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During reset and in idle, every lane enable, the write strobe and the output enable are high (inactive), and `mem_dq_oe_o` is 0.
- R2: `req_ready_o` is high only in idle. A write with a nonzero mask keeps it low for WP+2 cycles after the accepting edge. A read with a nonzero mask keeps it low for RD+TURN cycles.
- R3: Lane i (data bits 8i+7..8i) has its enable `mem_ce_n_o[i]` driven low during an access only if mask bit i is 1. All lanes with mask bit 1 are low for the whole access.
- R4: A write drives address, data and enables for one setup cycle. It then holds the write strobe low for WP = max(1, ceil(max(T_WP_NS, T_DSU_NS)/CLK_PERIOD_NS)) consecutive cycles, with address, data and enables stable throughout. Data stays driven for one cycle after the strobe rises.
- R5: A read holds the output enable and the selected lane enables low for RD = max(1, ceil(T_ACC_NS/CLK_PERIOD_NS)) cycles. `rsp_valid_o` goes high RD cycles after the accepting edge.
- R6: Read data carries the memory's byte in each lane selected by the mask and zero in every unselected lane.
- R7: After a memory read, `rsp_valid_o` is high for exactly one cycle.
- R8: A request with mask 0 drives no memory strobe, and `req_ready_o` stays high. A zero-mask write leaves memory unchanged. A zero-mask read raises `rsp_valid_o` in the next cycle with data 0.
- R9: `mem_dq_oe_o` is never high while `mem_oe_n_o` is low. After a read, at least TURN = max(1, ceil(T_OHZ_NS/CLK_PERIOD_NS)) cycles pass with the output enable high and the driver off before the bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted this edge |
| req_addr_i | input | 18 | Word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write data |
| req_mask_i | input | 4 | Byte-lane mask, bit i selects bits 8i+7..8i |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 32 | Read data, unselected lanes zero |
| mem_addr_o | output | 18 | Memory address |
| mem_ce_n_o | output | 4 | Per-lane enables, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_oe_o | output | 1 | Data-bus driver enable |
| mem_dq_o | output | 32 | Data driven to memory |
| mem_dq_i | input | 32 | Data returned by memory |

## Verification
The bench builds the controller with a 20 ns clock, a 45 ns access time, a 25 ns strobe width and a 9 ns float time. These values give a three-cycle read wait, a two-cycle write strobe and a one-cycle turnaround. With waits longer than one cycle, the counter reload and decrement paths are exercised, and an off-by-one in either would show in the measured latencies. A read followed at once by a write checks the turnaround gap. Mixed and zero masks check the per-lane enable and merge behaviour against a byte-accurate memory model.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WSU,
        ST_WPULSE,
        ST_WHOLD
    } ctl_st_e;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned p_ns);
        int unsigned c;
        c = (t_ns + p_ns - 1) / p_ns;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_lane_cnt.sv
module sram_lane_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (dec_i && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_cap.sv
module sram_lane_cap #(
    parameter int unsigned LANES = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [LANES-1:0]   mask_i,
    input  logic [LANES*8-1:0] din_i,
    output logic [LANES*8-1:0] dout_o
);
    logic [LANES*8-1:0] data_d, data_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            data_d[g*8 +: 8] = data_q[g*8 +: 8];
            if (en_i)
                data_d[g*8 +: 8] = mask_i[g] ? din_i[g*8 +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) data_q <= '0;
        else         data_q <= data_d;
    end

    assign dout_o = data_q;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned T_ACC_NS      = 12,
    parameter int unsigned T_WP_NS       = 8,
    parameter int unsigned T_DSU_NS      = 6,
    parameter int unsigned T_OHZ_NS      = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic                 req_we_i,
    input  logic [DATA_W-1:0]    req_wdata_i,
    input  logic [DATA_W/8-1:0]  req_mask_i,
    output logic                 rsp_valid_o,
    output logic [DATA_W-1:0]    rsp_rdata_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    output logic [DATA_W/8-1:0]  mem_ce_n_o,
    output logic                 mem_we_n_o,
    output logic                 mem_oe_n_o,
    output logic                 mem_dq_oe_o,
    output logic [DATA_W-1:0]    mem_dq_o,
    input  logic [DATA_W-1:0]    mem_dq_i
);
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned RD_CYC  = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
    localparam int unsigned WP_NS   = (T_WP_NS > T_DSU_NS) ? T_WP_NS : T_DSU_NS;
    localparam int unsigned WP_CYC  = ns_to_cyc(WP_NS, CLK_PERIOD_NS);
    localparam int unsigned TRN_CYC = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC = (RD_CYC > WP_CYC) ?
                                      ((RD_CYC > TRN_CYC) ? RD_CYC : TRN_CYC) :
                                      ((WP_CYC > TRN_CYC) ? WP_CYC : TRN_CYC);
    localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        ctl_st_e              st;
        logic [ADDR_W-1:0]    addr;
        logic [LANES-1:0]     mask;
        logic [LANES-1:0]     ce_n;
        logic                 we_n;
        logic                 oe_n;
        logic                 dq_oe;
        logic [DATA_W-1:0]    wdata;
        logic                 rvalid;
    } ctl_s;

    ctl_s s_d, s_q;

    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic             cap_en;
    logic [LANES-1:0] cap_mask;

    always_comb begin
        s_d      = s_q;
        s_d.rvalid = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        cap_en   = 1'b0;
        cap_mask = s_q.mask;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (req_mask_i == '0) begin
                        if (!req_we_i) begin
                            cap_en     = 1'b1;
                            cap_mask   = '0;
                            s_d.rvalid = 1'b1;
                        end
                    end else begin
                        s_d.addr  = req_addr_i;
                        s_d.mask  = req_mask_i;
                        s_d.wdata = req_wdata_i;
                        s_d.ce_n  = ~req_mask_i;
                        if (req_we_i) begin
                            s_d.st    = ST_WSU;
                            s_d.dq_oe = 1'b1;
                        end else begin
                            s_d.st   = ST_RD;
                            s_d.oe_n = 1'b0;
                            cnt_load = 1'b1;
                            cnt_val  = CNT_W'(RD_CYC - 1);
                        end
                    end
                end
            end
            ST_RD: begin
                if (cnt_zero) begin
                    cap_en     = 1'b1;
                    s_d.rvalid = 1'b1;
                    s_d.ce_n   = '1;
                    s_d.oe_n   = 1'b1;
                    s_d.st     = ST_TURN;
                    cnt_load   = 1'b1;
                    cnt_val    = CNT_W'(TRN_CYC - 1);
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_TURN: begin
                if (cnt_zero) s_d.st = ST_IDLE;
                else          cnt_dec = 1'b1;
            end
            ST_WSU: begin
                s_d.we_n = 1'b0;
                s_d.st   = ST_WPULSE;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(WP_CYC - 1);
            end
            ST_WPULSE: begin
                if (cnt_zero) begin
                    s_d.we_n = 1'b1;
                    s_d.st   = ST_WHOLD;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_WHOLD: begin
                s_d.ce_n  = '1;
                s_d.dq_oe = 1'b0;
                s_d.st    = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q        <= '0;
            s_q.st     <= ST_IDLE;
            s_q.ce_n   <= '1;
            s_q.we_n   <= 1'b1;
            s_q.oe_n   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    sram_lane_cnt #(.W(CNT_W)) cnt_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero)
    );

    sram_lane_cap #(.LANES(LANES)) cap_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (cap_en),
        .mask_i (cap_mask),
        .din_i  (mem_dq_i),
        .dout_o (rsp_rdata_o)
    );

    assign req_ready_o = (s_q.st == ST_IDLE);
    assign rsp_valid_o = s_q.rvalid;
    assign mem_addr_o  = s_q.addr;
    assign mem_ce_n_o  = s_q.ce_n;
    assign mem_we_n_o  = s_q.we_n;
    assign mem_oe_n_o  = s_q.oe_n;
    assign mem_dq_oe_o = s_q.dq_oe;
    assign mem_dq_o    = s_q.wdata;
endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 32
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                req_ready_o,
    input logic                rsp_valid_o,
    input logic [ADDR_W-1:0]   mem_addr_o,
    input logic [DATA_W/8-1:0] mem_ce_n_o,
    input logic                mem_we_n_o,
    input logic                mem_oe_n_o,
    input logic                mem_dq_oe_o,
    input logic [DATA_W-1:0]   mem_dq_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> ((&mem_ce_n_o) && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

    // R9
    bus_conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_oe_n_o |-> !mem_dq_oe_o);

    // R9
    turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_dq_oe_o) |-> $past(mem_oe_n_o));

    // R4
    strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mem_we_n_o && !$past(mem_we_n_o)) |->
            ($stable(mem_addr_o) && $stable(mem_dq_o) && $stable(mem_ce_n_o)));

    // R4
    write_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_we_n_o |-> (mem_dq_oe_o && $past(mem_dq_oe_o)));

    // R7
    rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !req_ready_o) |=> !rsp_valid_o);
endmodule

bind sram_lane_ctrl sram_lane_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .mem_dq_o    (mem_dq_o)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;
    localparam int RD  = 3;   // ceil(45/20)
    localparam int WP  = 2;   // ceil(max(25,6)/20)
    localparam int TRN = 1;   // ceil(9/20)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic [3:0]  mem_ce_n;
    logic        mem_we_n, mem_oe_n, mem_dq_oe;
    logic [31:0] mem_dq_o, mem_dq_i;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int conflicts = 0;
    int last_oe_cyc = -100;
    int first_drive_cyc = -1;

    logic [31:0] mem    [0:255];
    logic [31:0] shadow [0:255];

    always #10 clk = ~clk;

    sram_lane_ctrl #(
        .CLK_PERIOD_NS(20), .T_ACC_NS(45), .T_WP_NS(25), .T_DSU_NS(6), .T_OHZ_NS(9)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata), .req_mask_i(req_mask),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .mem_addr_o(mem_addr), .mem_ce_n_o(mem_ce_n), .mem_we_n_o(mem_we_n),
        .mem_oe_n_o(mem_oe_n), .mem_dq_oe_o(mem_dq_oe), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i)
    );

    // Behavioural memory: byte lanes written while strobe and lane enable are low.
    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++)
            if (!mem_we_n && !mem_ce_n[i])
                mem[mem_addr[7:0]][i*8 +: 8] <= mem_dq_o[i*8 +: 8];
    end

    always_comb begin
        mem_dq_i = '0;
        for (int i = 0; i < 4; i++)
            if (!mem_oe_n && mem_we_n && !mem_ce_n[i])
                mem_dq_i[i*8 +: 8] = mem[mem_addr[7:0]][i*8 +: 8];
    end

    // Bus monitor for the turnaround rule.
    always @(negedge clk) begin
        cyc++;
        if (mem_dq_oe && !mem_oe_n) conflicts++;
        if (!mem_oe_n) last_oe_cyc = cyc;
        if (mem_dq_oe && first_drive_cyc < 0) first_drive_cyc = cyc;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_expand(input logic [3:0] m);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = {8{m[i]}};
        return r;
    endfunction

    // Present one request; returns at the first negedge after the accepting edge.
    task automatic issue(input logic [17:0] a, input logic we, input logic [31:0] d, input logic [3:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_we = we; req_wdata = d; req_mask = m; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
        check(mem_ce_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes idle",
              {25'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, {25'd0, 4'hF, 3'b110});
        check(rsp_valid == 1'b0, "R7 no valid in reset", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_write(input logic [17:0] a, input logic [31:0] d, input logic [3:0] m);
        int low = 0, n = 1, ready_at = 0;
        bit bad = 0, seen_low = 0, drive_after = 0;
        issue(a, 1'b1, d, m);
        while (!req_ready && n < 40) begin
            if (!mem_we_n) begin
                low++; seen_low = 1;
                if (mem_addr != a || mem_dq_o != d || !mem_dq_oe || mem_ce_n != ~m) bad = 1;
            end else if (seen_low) begin
                drive_after = mem_dq_oe;
            end
            if (mem_ce_n != ~m) bad = 1;
            @(negedge clk); n++;
        end
        ready_at = n;
        check(low == WP, "R4 strobe width", low, WP);
        check(!bad, "R4 R3 addr data enables stable during strobe", {31'd0, bad}, 32'd0);
        check(drive_after, "R4 data held after strobe", {31'd0, drive_after}, 32'd1);
        check(ready_at == WP + 3, "R2 write busy length", ready_at, WP + 3);
        for (int i = 0; i < 4; i++)
            if (m[i]) shadow[a[7:0]][i*8 +: 8] = d[i*8 +: 8];
    endtask

    task automatic t_read(input logic [17:0] a, input logic [3:0] m);
        int n = 1;
        bit bad = 0;
        logic [31:0] exp;
        exp = shadow[a[7:0]] & lane_expand(m);
        issue(a, 1'b0, 32'h0, m);
        while (!rsp_valid && n < 40) begin
            if (mem_ce_n != ~m || mem_oe_n || mem_dq_oe) bad = 1;
            @(negedge clk); n++;
        end
        check(n == RD + 1, "R5 read latency", n, RD + 1);
        check(!bad, "R3 R5 lane enables and output enable during read", {31'd0, bad}, 32'd0);
        check(rsp_rdata == exp, "R6 read data", rsp_rdata, exp);
        @(negedge clk);
        check(!rsp_valid, "R7 valid one cycle", {31'd0, rsp_valid}, 32'd0);
        check(req_ready == (TRN == 1), "R2 ready after turnaround", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_zero_write(input logic [17:0] a);
        issue(a, 1'b1, 32'hFFFF_FFFF, 4'h0);
        check(req_ready && mem_ce_n == 4'hF && mem_we_n, "R8 zero-mask write no strobe",
              {26'd0, req_ready, mem_ce_n, mem_we_n}, {26'd0, 1'b1, 4'hF, 1'b1});
        t_read(a, 4'hF);
    endtask

    task automatic t_zero_read();
        issue(18'h3, 1'b0, 32'h0, 4'h0);
        check(rsp_valid && rsp_rdata == 32'h0, "R8 zero-mask read data", rsp_rdata, 32'h0);
        check(mem_oe_n && mem_ce_n == 4'hF && req_ready, "R8 zero-mask read no strobe",
              {27'd0, mem_oe_n, mem_ce_n}, {27'd0, 1'b1, 4'hF});
    endtask

    task automatic t_read_then_write();
        first_drive_cyc = -1;
        issue(18'h21, 1'b0, 32'h0, 4'hF);
        issue(18'h22, 1'b1, 32'hCAFE_F00D, 4'hF);
        while (!req_ready) @(negedge clk);
        check(first_drive_cyc - last_oe_cyc - 1 >= TRN, "R9 turnaround gap",
              first_drive_cyc - last_oe_cyc - 1, TRN);
        shadow[8'h22] = 32'hCAFE_F00D;
        t_read(18'h22, 4'hF);
        check(conflicts == 0, "R9 no bus conflict", conflicts, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = (i * 32'h0101_0101) ^ 32'h5A00_00A5;
            shadow[i] = (i * 32'h0101_0101) ^ 32'h5A00_00A5;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(18'h10, 32'h1122_3344, 4'hF);
        t_read(18'h10, 4'hF);
        t_write(18'h11, 32'hAABB_CCDD, 4'b0101);
        t_read(18'h11, 4'hF);
        t_read(18'h11, 4'b1010);
        t_write(18'h12, 32'h0F0F_0F0F, 4'b1000);
        t_read(18'h12, 4'b1001);
        t_zero_write(18'h13);
        t_zero_read();
        t_read_then_write();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", 5000, 5000);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule